// File: doc/BRIEF.md
# Shadowed SRAM with Bulk Store and Recall

A clocked model of a word-addressed static memory (2048 words of 8 bits by default) in which every word has a partner word in a second, nonvolatile array. Four active-low control inputs (chip select, write, output enable and nonvolatile select) are decoded each clock into one operating mode: ordinary reads and writes, or a bulk copy in either direction between the working array and the shadow array. A bulk copy from working memory to shadow is a "store"; the opposite direction is a "recall".

Both bulk copies are self-timed. A counter holds `busy` high for a parameterised number of clocks and copies one word per clock. A store starts only after its pin pattern has been held for `STORE_INIT_CYC` clocks and the supply reads at least `STORE_MIN_MV`. Once it has started it runs to the end whatever the pins do. A supply rising above `RECALL_MV` starts a recall by itself. This includes the first clocks after reset when the supply is already high. While either copy runs, the data outputs stay disabled, reads and writes are dropped, and the standby indication stays low.

The supply is given as a reading in millivolts. The cycle counts must be at least the memory depth so that every word is copied before `busy` falls.

Top module: `shadow_sram`

## Requirements
- R1: With `ce_n` = 1 the block is deselected: `dout_en` is 0 on the next clock, no word is written, and no copy starts, whatever `we_n`, `oe_n` and `ne_n` are.
- R2: With `ce_n`=0, `ne_n`=1, `we_n`=1, `oe_n`=0 and `busy`=0 at a rising edge, `dout_en` is 1 after that edge and `dout` holds the word at `addr`.
- R3: With `ce_n`=0, `ne_n`=1, `we_n`=0 and `busy`=0 at a rising edge, `din` is written to `addr` whatever `oe_n` is, and `dout_en` is 0 after that edge.
- R4: The patterns `ce_n`=0 with `we_n`=`oe_n`=`ne_n`=0, and `ce_n`=0 with `we_n`=`oe_n`=1 (either `ne_n`), neither read, write nor start a copy.
- R5: `ce_n`=0, `we_n`=1, `oe_n`=0, `ne_n`=0 at an edge with `busy`=0 starts a recall. `busy` is then high for exactly `RECALL_CYC` clocks, and afterwards every working word equals its shadow word.
- R6: `ce_n`=0, `we_n`=0, `oe_n`=1, `ne_n`=0 held at `STORE_INIT_CYC` consecutive edges with `busy`=0 starts a store. `busy` is then high for exactly `STORE_CYC` clocks, and afterwards every shadow word equals its working word.
- R7: A store pattern held for fewer than `STORE_INIT_CYC` edges starts nothing. A started store completes even when all control pins return high on the next clock.
- R8: While `supply_mv` is below `STORE_MIN_MV` (4000), a store pattern starts nothing and resets the hold count.
- R9: At an edge where `supply_mv` is above `RECALL_MV` (4250) and at the previous edge (or at reset) it was not, a recall starts if `busy`=0. This takes priority over pin requests.
- R10: While `busy` is 1, reads and writes have no effect: `dout_en` is 0 on the following clock and no word changes.
- R11: `standby` is 1 exactly when `ce_n` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state (arrays are not cleared) |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ne_n | input | 1 | Nonvolatile select, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| supply_mv | input | SUP_W | Supply reading in millivolts |
| dout | output | DATA_W | Read data, valid when dout_en is 1 |
| dout_en | output | 1 | Output drive enable (0 stands for high impedance) |
| busy | output | 1 | A store or recall is running |
| standby | output | 1 | Deselected and no copy running |

## Verification
The shadow array cannot be read directly, so its contents can only be seen through a recall. The bench stores one pattern, overwrites the working array with a second one, and then recalls. A read-back sweep then shows whether the store copied every word. The undervoltage and power-up paths are reached by moving `supply_mv` across both thresholds between operations, including a rise from between the thresholds to above 4250. The bench also releases the store pattern one clock short of the hold time to reach the edge of the initiation count.

// File: rtl/shadow_sram_pkg.sv
package shadow_sram_pkg;

  typedef enum logic [2:0] {
    MD_DESEL  = 3'd0,
    MD_READ   = 3'd1,
    MD_WRITE  = 3'd2,
    MD_RECALL = 3'd3,
    MD_STORE  = 3'd4,
    MD_NOP    = 3'd5
  } mode_e;

  // Pin pattern to operating mode; inputs are the active-low pins.
  function automatic mode_e pins_to_mode(input logic ce_n, input logic we_n,
                                         input logic oe_n, input logic ne_n);
    mode_e m;
    if (ce_n)                 m = MD_DESEL;
    else if (ne_n) begin
      if (!we_n)              m = MD_WRITE;
      else if (!oe_n)         m = MD_READ;
      else                    m = MD_NOP;
    end else begin
      if (we_n && !oe_n)      m = MD_RECALL;
      else if (!we_n && oe_n) m = MD_STORE;
      else                    m = MD_NOP;
    end
    return m;
  endfunction

  function automatic logic mv_above(input int unsigned mv, input int unsigned thr);
    return mv > thr;
  endfunction

  function automatic logic mv_at_least(input int unsigned mv, input int unsigned thr);
    return mv >= thr;
  endfunction

endpackage

// File: rtl/ss_mode_decode.sv
module ss_mode_decode
  import shadow_sram_pkg::*;
(
  input  logic  ce_n,
  input  logic  we_n,
  input  logic  oe_n,
  input  logic  ne_n,
  output mode_e mode
);
  always_comb mode = pins_to_mode(ce_n, we_n, oe_n, ne_n);
endmodule

// File: rtl/ss_nv_seq.sv
module ss_nv_seq
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int SUP_W          = 13,
  parameter int STORE_CYC      = 4096,
  parameter int RECALL_CYC     = 2304,
  parameter int STORE_INIT_CYC = 4,
  parameter int RECALL_MV      = 4250,
  parameter int STORE_MIN_MV   = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [SUP_W-1:0]  supply_mv,
  output logic              busy,
  output logic              op_store,
  output logic              copy_en,
  output logic [ADDR_W-1:0] copy_idx,
  output logic              store_start,
  output logic              recall_start,
  output logic              pwr_rise
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAXC   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int INIT_W = $clog2(STORE_INIT_CYC + 1);

  logic              supply_hi_q;
  logic              supply_hi;
  logic              store_ok;
  logic [INIT_W-1:0] hold_q;
  logic              store_armed;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_cnt;
  logic              busy_q;
  logic              kind_store_q;

  always_comb begin
    supply_hi    = mv_above(int'(supply_mv), RECALL_MV);
    store_ok     = mv_at_least(int'(supply_mv), STORE_MIN_MV);
    pwr_rise     = supply_hi && !supply_hi_q;
    store_armed  = (mode == MD_STORE) && store_ok && !busy_q &&
                   (int'(hold_q) == STORE_INIT_CYC - 1);
    recall_start = !busy_q && (pwr_rise || (mode == MD_RECALL && !store_armed));
    store_start  = !busy_q && !pwr_rise && store_armed;
    last_cnt     = kind_store_q ? CNT_W'(STORE_CYC - 1) : CNT_W'(RECALL_CYC - 1);
  end

  // Consecutive-edge count of a valid store pattern.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (busy_q || mode != MD_STORE || !store_ok) begin
      hold_q <= '0;
    end else if (int'(hold_q) < STORE_INIT_CYC) begin
      hold_q <= hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_hi_q  <= 1'b0;
      busy_q       <= 1'b0;
      kind_store_q <= 1'b0;
      cnt_q        <= '0;
    end else begin
      supply_hi_q <= supply_hi;
      if (busy_q) begin
        if (cnt_q == last_cnt) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end else if (store_start || recall_start) begin
        busy_q       <= 1'b1;
        kind_store_q <= store_start;
        cnt_q        <= '0;
      end
    end
  end

  assign busy     = busy_q;
  assign op_store = kind_store_q;
  assign copy_en  = busy_q && (int'(cnt_q) < DEPTH);
  assign copy_idx = cnt_q[ADDR_W-1:0];
endmodule

// File: rtl/ss_arrays.sv
module ss_arrays #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              copy_en,
  input  logic              copy_store,
  input  logic [ADDR_W-1:0] copy_idx,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_mem   [DEPTH];
  logic [DATA_W-1:0] shadow_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (copy_en && !copy_store) work_mem[copy_idx] <= shadow_mem[copy_idx];
    else if (wr_en)             work_mem[addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (copy_en && copy_store) shadow_mem[copy_idx] <= work_mem[copy_idx];
  end

  always_ff @(posedge clk) begin
    dout <= work_mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_en <= 1'b0;
    else        dout_en <= rd_en;
  end
endmodule

// File: rtl/shadow_sram.sv
module shadow_sram
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 8,
  parameter int SUP_W          = 13,
  parameter int STORE_CYC      = 4096,
  parameter int RECALL_CYC     = 2304,
  parameter int STORE_INIT_CYC = 4,
  parameter int RECALL_MV      = 4250,
  parameter int STORE_MIN_MV   = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ne_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [SUP_W-1:0]  supply_mv,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              standby
);
  mode_e             mode;
  logic              op_store;
  logic              copy_en;
  logic [ADDR_W-1:0] copy_idx;
  logic              store_start;
  logic              recall_start;
  logic              pwr_rise;
  logic              rd_en;
  logic              wr_en;

  ss_mode_decode u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ne_n(ne_n), .mode(mode)
  );

  ss_nv_seq #(
    .ADDR_W(ADDR_W), .SUP_W(SUP_W), .STORE_CYC(STORE_CYC),
    .RECALL_CYC(RECALL_CYC), .STORE_INIT_CYC(STORE_INIT_CYC),
    .RECALL_MV(RECALL_MV), .STORE_MIN_MV(STORE_MIN_MV)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .supply_mv(supply_mv),
    .busy(busy), .op_store(op_store), .copy_en(copy_en), .copy_idx(copy_idx),
    .store_start(store_start), .recall_start(recall_start), .pwr_rise(pwr_rise)
  );

  assign rd_en   = (mode == MD_READ)  && !busy;
  assign wr_en   = (mode == MD_WRITE) && !busy;
  assign standby = ce_n && !busy;

  ss_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .din(din), .copy_en(copy_en), .copy_store(op_store), .copy_idx(copy_idx),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/shadow_sram_chk.sv
module shadow_sram_chk #(
  parameter int SUP_W        = 13,
  parameter int STORE_CYC    = 4096,
  parameter int RECALL_CYC   = 2304,
  parameter int STORE_MIN_MV = 4000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             dout_en,
  input logic             op_store,
  input logic             store_start,
  input logic             recall_start,
  input logic [SUP_W-1:0] supply_mv
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  // R5 / R6: a copy lasts exactly its configured number of clocks
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == (op_store ? STORE_CYC : RECALL_CYC)));

  // R6: starts only from idle, never two kinds at once
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> (!busy && $onehot0({store_start, recall_start})));

  // R8: a store never begins from a low supply
  p_store_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && op_store) |-> ($past(supply_mv) >= SUP_W'(STORE_MIN_MV)));

  // R10: no output drive follows a busy clock
  p_no_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_en);
endmodule

bind shadow_sram shadow_sram_chk #(
  .SUP_W(SUP_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC),
  .STORE_MIN_MV(STORE_MIN_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dout_en(dout_en), .op_store(op_store),
  .store_start(store_start), .recall_start(recall_start), .supply_mv(supply_mv)
);

// File: tb/sim_shadow_sram.sv
module sim_shadow_sram;
  localparam int CLK_PER = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SW = 13;
  localparam int DEPTH = 1 << AW;
  localparam int ST_CYC = 24;
  localparam int RC_CYC = 20;
  localparam int INIT = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, ne_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [SW-1:0] supply_mv = SW'(4500);
  logic [DW-1:0] dout;
  logic dout_en, busy, standby;

  always #(CLK_PER/2) clk = ~clk;

  shadow_sram #(.ADDR_W(AW), .DATA_W(DW), .SUP_W(SW), .STORE_CYC(ST_CYC),
    .RECALL_CYC(RC_CYC), .STORE_INIT_CYC(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ne_n(ne_n),
    .addr(addr), .din(din), .supply_mv(supply_mv), .dout(dout), .dout_en(dout_en),
    .busy(busy), .standby(standby));

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R9";

  // ---- behavioural reference model ----
  int  w_mem [DEPTH];  bit w_ok [DEPTH];
  int  s_mem [DEPTH];  bit s_ok [DEPTH];
  bit  m_busy = 0, m_store = 0, m_hi = 0, m_dv = 0, m_dok = 0;
  int  m_left = 0, m_hold = 0, m_dout = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_hi = 0; m_dv = 0; m_hold = 0;
    end else begin
      bit rd, wr, rc, st, ok, rise, was_busy;
      rd = !ce_n && ne_n && we_n && !oe_n;
      wr = !ce_n && ne_n && !we_n;
      rc = !ce_n && !ne_n && we_n && !oe_n;
      st = !ce_n && !ne_n && !we_n && oe_n;
      ok = supply_mv >= 4000;
      rise = (supply_mv > 4250) && !m_hi;
      m_hi = supply_mv > 4250;
      was_busy = m_busy;
      m_dv = rd && !was_busy;
      m_dout = w_mem[addr]; m_dok = w_ok[addr];
      if (was_busy) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
      end else begin
        if (wr) begin w_mem[addr] = din; w_ok[addr] = 1; end
        if (rise || (!(st && ok && m_hold == INIT-1) && rc)) begin
          for (int i = 0; i < DEPTH; i++) begin w_mem[i] = s_mem[i]; w_ok[i] = s_ok[i]; end
          m_busy = 1; m_store = 0; m_left = RC_CYC;
        end else if (st && ok && m_hold == INIT-1) begin
          for (int i = 0; i < DEPTH; i++) begin s_mem[i] = w_mem[i]; s_ok[i] = w_ok[i]; end
          m_busy = 1; m_store = 1; m_left = ST_CYC;
        end
      end
      if (was_busy || !st || !ok) m_hold = 0;
      else if (m_hold < INIT) m_hold++;
    end
  end

  task automatic chk(input bit got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(busy, m_busy, "busy");
      chk(dout_en, m_dv, "dout_en");
      chk(standby, ce_n && !m_busy, "standby (R11)");
      if (m_dv && m_dok) begin
        checks++;
        if (dout !== DW'(m_dout)) begin
          fails++;
          $display("FAIL %s dout: actual %0h expected %0h", cur_req, dout, m_dout);
        end
      end
    end
  end

  task automatic pins(input bit c, input bit w, input bit o, input bit n,
                      input int a, input int d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; ne_n = n; addr = AW'(a); din = DW'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pins(1, 1, 1, 1, 0, 0);
  endtask

  task automatic fill(input int base, input bit oe);
    for (int a = 0; a < DEPTH; a++) pins(0, 0, oe, 1, a, base + a * 7);
  endtask

  task automatic sweep();
    for (int a = 0; a < DEPTH; a++) pins(0, 1, 0, 1, a, 0);
    idle(1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin w_ok[i] = 0; s_ok[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R9"; idle(RC_CYC + 3);          // power-up recall after reset
    cur_req = "R1";
    pins(1, 0, 0, 1, 2, 8'h55); pins(1, 1, 0, 1, 2, 0); pins(1, 1, 0, 0, 0, 0);
    pins(1, 0, 1, 0, 0, 0); idle(2);
    cur_req = "R3"; fill(8'h10, 0); fill(8'h20, 1);
    cur_req = "R2"; sweep();
    cur_req = "R4";
    pins(0, 0, 0, 0, 1, 8'hEE); pins(0, 1, 1, 0, 1, 8'hEE); pins(0, 1, 1, 1, 1, 8'hEE);
    pins(0, 1, 0, 1, 1, 0); idle(2);
    cur_req = "R7";                               // one edge short of the hold
    for (int i = 0; i < INIT - 1; i++) pins(0, 0, 1, 0, 0, 0);
    idle(3);
    cur_req = "R6";
    for (int i = 0; i < INIT; i++) pins(0, 0, 1, 0, 0, 0);
    cur_req = "R11"; pins(1, 1, 1, 1, 0, 0);      // release pins, deselect while busy
    idle(ST_CYC + 2);
    cur_req = "R3"; fill(8'h80, 0);
    cur_req = "R5"; pins(0, 1, 0, 0, 0, 0);
    cur_req = "R10";
    for (int a = 0; a < 6; a++) begin pins(0, 0, 1, 1, a, 8'hAA); pins(0, 1, 0, 1, a, 0); end
    idle(RC_CYC);
    cur_req = "R5"; sweep();
    cur_req = "R8"; supply_mv = SW'(3900);
    for (int i = 0; i < INIT + 2; i++) pins(0, 0, 1, 0, 0, 0);
    idle(3);
    supply_mv = SW'(4100);
    cur_req = "R3"; fill(8'h40, 1);
    cur_req = "R8";
    for (int i = 0; i < INIT; i++) pins(0, 0, 1, 0, 0, 0);
    idle(ST_CYC + 2);
    cur_req = "R3"; fill(8'hC0, 0);
    cur_req = "R9"; supply_mv = SW'(4250); idle(2);
    supply_mv = SW'(4300); idle(RC_CYC + 2);
    sweep();
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule